// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Watermark Flags

A first-in first-out buffer for 9-bit words whose write port and read port each run on their own clock. The two clocks may be one net or fully unrelated. A word is taken on a rising write-clock edge when both write enables are high. A word is removed on a rising read-clock edge when both read enables are high. Pointers cross between domains as Gray codes through two-flop synchronizers. The empty and almost-empty flags are formed in the read domain, and the full and almost-full flags in the write domain.

The stream rules are as follows. On the write side, the enable pair acts as *valid* and a low `full` acts as *ready*. A write attempted while `full` is high is dropped, and the writer must wait for `full` to fall. On the read side, the enable pair acts as the consumer's request and a low `empty` acts as *valid*. A read attempted while `empty` is high does nothing, and the output register keeps its previous word. Read data appears in an output register after the accepting read-clock edge. `out_en` stands in for a three-state output enable: it zeroes the data bus and drives the qualifier `rd_data_vld`.

Two watermark offsets set the almost flags. They reset to 7. While `load` is high, accepted write cycles store the data bits into the offsets instead of the RAM, alternating empty-offset then full-offset. Read cycles with `load` high return the offsets in the same alternating order, each with its own sequence. `load` is expected to be held steady across both clock domains while it is in use. `DEPTH` must be a power of two no larger than 512, so that an offset fits in one data word.

Top module: `fifo9_dc`

## Requirements
- R1: A word on `wr_data` is stored when both `wr_ena_a` and `wr_ena_b` are high at a rising `wclk` edge with `load` low and `full` low. Stored words are read back in the order written, and the write pointer advances by at most one per edge.
- R2: When both `rd_ena_a` and `rd_ena_b` are high at a rising `rclk` edge with `load` low and `empty` low, the oldest word is loaded into the output register and appears on `rd_data` after that edge.
- R3: A write while `full` is high is dropped and never read out. A read while `empty` is high leaves the pointers and `rd_data` unchanged.
- R4: `empty` is high when no words are held as seen by the read domain. It falls within three `rclk` edges after the first write is visible.
- R5: `full` is high when `DEPTH` words are held as seen by the write domain, and falls after enough reads are synchronized.
- R6: `almost_empty` is high when the held count is less than or equal to the empty offset. The empty offset resets to 7.
- R7: `almost_full` is high when the held count is greater than or equal to `DEPTH` minus the full offset. The full offset resets to 7.
- R8: With `load` high, each accepted write cycle stores `wr_data[AW-1:0]` into the offsets instead of the RAM. The first such cycle writes the empty offset and the second writes the full offset, after which the order repeats. The write pointer does not move.
- R9: With `load` high, each read cycle loads the output register with an offset, zero-extended: the empty offset first, then the full offset, repeating. The read pointer does not move.
- R10: When `out_en` is low, `rd_data` is all zeros and `rd_data_vld` is low. When `out_en` is high, `rd_data` shows the output register and `rd_data_vld` is high.
- R11: Asserting `rst_n` low clears both pointers and the output register, sets `empty` and clears `full`, restores both offsets to 7, and returns both offset sequences to the empty offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Redirects both ports to the offset registers |
| wr_ena_a | input | 1 | Write enable, first of pair |
| wr_ena_b | input | 1 | Write enable, second of pair |
| wr_data | input | DW | Write data |
| full | output | 1 | FIFO holds DEPTH words (write domain) |
| almost_full | output | 1 | Count at or above DEPTH minus full offset |
| rd_ena_a | input | 1 | Read enable, first of pair |
| rd_ena_b | input | 1 | Read enable, second of pair |
| out_en | input | 1 | Output enable for the read bus |
| rd_data | output | DW | Read data, zero when out_en is low |
| rd_data_vld | output | 1 | Read bus qualifier, follows out_en |
| empty | output | 1 | No words held (read domain) |
| almost_empty | output | 1 | Count at or below empty offset |

## Verification
On every clock edge the checker confirms four things: a full or empty flag freezes its pointer, load cycles leave both pointers alone, the write pointer moves by at most one step, and each hard flag implies its almost flag. Word ordering, the dropping of a write at full, the exact watermark thresholds under default and loaded offsets, the alternating order of offset load and readback, and the restoration of defaults by reset depend on data values across long sequences. Only the scoreboard scenarios in the bench can show those.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;
  localparam int GW = 16;

  function automatic logic [GW-1:0] to_gray(input logic [GW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GW-1:0] from_gray(input logic [GW-1:0] g);
    logic [GW-1:0] b;
    b[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/fifo9_sync.sv
module fifo9_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fifo9_ram.sv
module fifo9_ram #(
  parameter int DW    = 9,
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fifo9_wr_side.sv
module fifo9_wr_side
  import fifo9_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int AW     = 8,
  parameter int AE_DEF = 7,
  parameter int AF_DEF = 7
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_ena_a,
  input  logic          wr_ena_b,
  input  logic          load,
  input  logic [AW-1:0] ofs_in,
  input  logic [AW:0]   rgray_s,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [AW:0]   wptr_bin,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          almost_full,
  output logic [AW-1:0] ae_ofs,
  output logic [AW-1:0] af_ofs
);
  localparam int PW = AW + 1;

  logic          wr_req;
  logic          push;
  logic          ofs_wr;
  logic          seq;
  logic [PW-1:0] wbin;
  logic [PW-1:0] rsync_bin;
  logic [PW-1:0] used;

  always_comb begin
    wr_req    = wr_ena_a && wr_ena_b;
    rsync_bin = PW'(from_gray(GW'(rgray_s)));
    used      = wbin - rsync_bin;
    full      = (used == PW'(DEPTH));
    almost_full = (used >= (PW'(DEPTH) - PW'(af_ofs)));
    push      = wr_req && !load && !full;
    ofs_wr    = wr_req && load;
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin + PW'(1);
      wgray <= PW'(to_gray(GW'(wbin + PW'(1))));
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      ae_ofs <= AW'(AE_DEF);
      af_ofs <= AW'(AF_DEF);
      seq    <= 1'b0;
    end else if (ofs_wr) begin
      if (!seq) ae_ofs <= ofs_in;
      else      af_ofs <= ofs_in;
      seq <= ~seq;
    end
  end

  assign ram_we    = push;
  assign ram_waddr = wbin[AW-1:0];
  assign wptr_bin  = wbin;
endmodule

// File: rtl/fifo9_rd_side.sv
module fifo9_rd_side
  import fifo9_pkg::*;
#(
  parameter int DW = 9,
  parameter int AW = 8
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          rd_ena_a,
  input  logic          rd_ena_b,
  input  logic          load,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] ram_rdata,
  input  logic [AW-1:0] ae_ofs,
  input  logic [AW-1:0] af_ofs,
  output logic [AW-1:0] ram_raddr,
  output logic [AW:0]   rptr_bin,
  output logic [AW:0]   rgray,
  output logic          empty,
  output logic          almost_empty,
  output logic [DW-1:0] q_reg
);
  localparam int PW = AW + 1;

  logic          rd_req;
  logic          pop;
  logic          ofs_rd;
  logic          seq;
  logic [PW-1:0] rbin;
  logic [PW-1:0] wsync_bin;
  logic [PW-1:0] avail;
  logic [DW-1:0] ofs_word;

  always_comb begin
    rd_req       = rd_ena_a && rd_ena_b;
    wsync_bin    = PW'(from_gray(GW'(wgray_s)));
    avail        = wsync_bin - rbin;
    empty        = (rgray == wgray_s);
    almost_empty = (avail <= {1'b0, ae_ofs});
    pop          = rd_req && !load && !empty;
    ofs_rd       = rd_req && load;
    ofs_word     = '0;
    ofs_word[AW-1:0] = seq ? af_ofs : ae_ofs;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (pop) begin
      rbin  <= rbin + PW'(1);
      rgray <= PW'(to_gray(GW'(rbin + PW'(1))));
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      q_reg <= '0;
      seq   <= 1'b0;
    end else if (pop) begin
      q_reg <= ram_rdata;
    end else if (ofs_rd) begin
      q_reg <= ofs_word;
      seq   <= ~seq;
    end
  end

  assign ram_raddr = rbin[AW-1:0];
  assign rptr_bin  = rbin;
endmodule

// File: rtl/fifo9_dc.sv
module fifo9_dc #(
  parameter int DW     = 9,
  parameter int DEPTH  = 256,
  parameter int AE_DEF = 7,
  parameter int AF_DEF = 7
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          wr_ena_a,
  input  logic          wr_ena_b,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          almost_full,
  input  logic          rd_ena_a,
  input  logic          rd_ena_b,
  input  logic          out_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_data_vld,
  output logic          empty,
  output logic          almost_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  logic [AW-1:0] ram_raddr;
  logic [DW-1:0] ram_rdata;
  logic [PW-1:0] wptr_bin;
  logic [PW-1:0] rptr_bin;
  logic [PW-1:0] wgray;
  logic [PW-1:0] rgray;
  logic [PW-1:0] wgray_s;
  logic [PW-1:0] rgray_s;
  logic [AW-1:0] ae_ofs;
  logic [AW-1:0] af_ofs;
  logic [DW-1:0] q_reg;

  fifo9_wr_side #(
    .DEPTH(DEPTH), .AW(AW), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)
  ) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wr_ena_a(wr_ena_a), .wr_ena_b(wr_ena_b),
    .load(load), .ofs_in(wr_data[AW-1:0]), .rgray_s(rgray_s),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .wptr_bin(wptr_bin),
    .wgray(wgray), .full(full), .almost_full(almost_full),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  fifo9_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .wclk(wclk), .we(ram_we), .waddr(ram_waddr), .wdata(wr_data),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  fifo9_sync #(.W(PW)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  fifo9_sync #(.W(PW)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  fifo9_rd_side #(.DW(DW), .AW(AW)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .rd_ena_a(rd_ena_a), .rd_ena_b(rd_ena_b),
    .load(load), .wgray_s(wgray_s), .ram_rdata(ram_rdata),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ram_raddr(ram_raddr),
    .rptr_bin(rptr_bin), .rgray(rgray), .empty(empty),
    .almost_empty(almost_empty), .q_reg(q_reg)
  );

  assign rd_data     = out_en ? q_reg : '0;
  assign rd_data_vld = out_en;
endmodule

// File: rtl/fifo9_dc_chk.sv
module fifo9_dc_chk #(
  parameter int DEPTH = 256
) (
  input logic                     wclk,
  input logic                     rclk,
  input logic                     rst_n,
  input logic                     load,
  input logic                     full,
  input logic                     almost_full,
  input logic                     empty,
  input logic                     almost_empty,
  input logic [$clog2(DEPTH):0]   wptr_bin,
  input logic [$clog2(DEPTH):0]   rptr_bin
);
  localparam int PW = $clog2(DEPTH) + 1;

  a_r3_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
    full |=> $stable(wptr_bin));

  a_r3_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |=> $stable(rptr_bin));

  a_r1_wr_step: assert property (@(posedge wclk) disable iff (!rst_n)
    1'b1 |=> ((wptr_bin == $past(wptr_bin)) ||
              (wptr_bin == PW'($past(wptr_bin) + PW'(1)))));

  a_r8_load_wr_hold: assert property (@(posedge wclk) disable iff (!rst_n)
    load |=> $stable(wptr_bin));

  a_r9_load_rd_hold: assert property (@(posedge rclk) disable iff (!rst_n)
    load |=> $stable(rptr_bin));

  a_r6_empty_implies_ae: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |-> almost_empty);

  a_r7_full_implies_af: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> almost_full);
endmodule

bind fifo9_dc fifo9_dc_chk #(.DEPTH(DEPTH)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .load(load),
  .full(full), .almost_full(almost_full), .empty(empty),
  .almost_empty(almost_empty), .wptr_bin(wptr_bin), .rptr_bin(rptr_bin)
);

// File: tb/test_fifo9_dc.sv
module test_fifo9_dc;
  localparam int DEPTH = 16;

  logic       wclk = 1'b0;
  logic       rclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic       wr_a = 1'b0, wr_b = 1'b0;
  logic [8:0] wdat = '0;
  logic       rd_a = 1'b0, rd_b = 1'b0;
  logic       out_en = 1'b1;
  logic       full, almost_full, empty, almost_empty, rd_data_vld;
  logic [8:0] rd_data;

  logic [8:0] exp_q[$];
  int n_chk = 0;
  int n_bad = 0;

  always #2 wclk = ~wclk;
  always #3 rclk = ~rclk;

  fifo9_dc #(.DW(9), .DEPTH(DEPTH), .AE_DEF(7), .AF_DEF(7)) i_fifo9_dc (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .load(load),
    .wr_ena_a(wr_a), .wr_ena_b(wr_b), .wr_data(wdat),
    .full(full), .almost_full(almost_full),
    .rd_ena_a(rd_a), .rd_ena_b(rd_b), .out_en(out_en),
    .rd_data(rd_data), .rd_data_vld(rd_data_vld),
    .empty(empty), .almost_empty(almost_empty)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // driver: one write cycle, expected word queued if the port is ready
  task automatic wr_push(input logic [8:0] d);
    @(negedge wclk);
    wr_a = 1'b1; wr_b = 1'b1; wdat = d;
    if (!full && !load) exp_q.push_back(d);
    @(negedge wclk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  // monitor: one read cycle, compare against the scoreboard
  task automatic rd_pop(input string req);
    logic [8:0] e;
    bit go;
    e = '0;
    @(negedge rclk);
    go = !empty && (exp_q.size() > 0);
    if (go) begin
      e = exp_q.pop_front();
      rd_a = 1'b1; rd_b = 1'b1;
    end
    @(negedge rclk);
    rd_a = 1'b0; rd_b = 1'b0;
    if (go) check(req, int'(rd_data), int'(e));
    else    check({req, " unexpected empty"}, exp_q.size(), 0);
  endtask

  task automatic rd_ofs(input string req, input int exp);
    @(negedge rclk);
    rd_a = 1'b1; rd_b = 1'b1;
    @(negedge rclk);
    rd_a = 1'b0; rd_b = 1'b0;
    check(req, int'(rd_data), exp);
  endtask

  task automatic settle();
    repeat (5) @(negedge rclk);
    repeat (5) @(negedge wclk);
  endtask

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge wclk);
    rst_n = 1'b1;
    settle();
    // R11 reset state
    check("R11 empty after reset", int'(empty), 1);
    check("R11 full after reset", int'(full), 0);
    check("R6 almost_empty at zero count", int'(almost_empty), 1);
    check("R7 almost_full at zero count", int'(almost_full), 0);
    check("R10 qualifier with out_en high", int'(rd_data_vld), 1);

    // R1 / R4 / R6: partial fill
    for (int i = 1; i <= 3; i++) wr_push(9'(i));
    settle();
    check("R4 empty falls after writes", int'(empty), 0);
    check("R6 almost_empty at count 3", int'(almost_empty), 1);
    for (int i = 4; i <= 8; i++) wr_push(9'(i));
    settle();
    check("R6 almost_empty at count 8", int'(almost_empty), 0);
    check("R7 almost_full at count 8", int'(almost_full), 0);
    wr_push(9'd9);
    settle();
    check("R7 almost_full at count 9", int'(almost_full), 1);
    for (int i = 10; i <= 16; i++) wr_push(9'(i * 17));
    settle();
    check("R5 full at DEPTH", int'(full), 1);
    // R3 write while full is dropped
    wr_push(9'h1AA);
    check("R3 full holds after dropped write", int'(full), 1);
    for (int i = 0; i < DEPTH; i++) rd_pop("R1 R2 R3 order after full");
    settle();
    check("R4 empty after drain", int'(empty), 1);
    check("R5 full falls after drain", int'(full), 0);
    // R3 read while empty holds output
    @(negedge rclk); rd_a = 1'b1; rd_b = 1'b1;
    @(negedge rclk); rd_a = 1'b0; rd_b = 1'b0;
    check("R3 read while empty keeps data", int'(rd_data), 16 * 17);
    // R10 output enable
    @(negedge rclk); out_en = 1'b0;
    @(negedge rclk);
    check("R10 data zero when disabled", int'(rd_data), 0);
    check("R10 qualifier low when disabled", int'(rd_data_vld), 0);
    out_en = 1'b1;
    @(negedge rclk);
    check("R10 data back when enabled", int'(rd_data), 16 * 17);

    // R8 / R9 offset load and readback
    @(negedge wclk); load = 1'b1;
    wr_push(9'd3);
    wr_push(9'd10);
    settle();
    check("R8 load writes bypass RAM", int'(empty), 1);
    rd_ofs("R9 readback empty offset", 3);
    rd_ofs("R9 readback full offset", 10);
    @(negedge wclk); load = 1'b0;
    settle();
    for (int i = 0; i < 4; i++) wr_push(9'(100 + i));
    settle();
    check("R6 almost_empty with offset 3 at count 4", int'(almost_empty), 0);
    check("R7 almost_full with offset 10 at count 4", int'(almost_full), 0);
    wr_push(9'd200);
    wr_push(9'd201);
    settle();
    check("R7 almost_full with offset 10 at count 6", int'(almost_full), 1);
    for (int i = 0; i < 6; i++) rd_pop("R2 order after offset load");
    settle();

    // R8 sequence wraps to the empty offset
    @(negedge wclk); load = 1'b1;
    wr_push(9'd5);
    settle();
    rd_ofs("R8 third load goes to empty offset", 5);
    rd_ofs("R8 full offset unchanged", 10);
    @(negedge wclk); load = 1'b0;

    // R11 reset mid-run restores defaults
    wr_push(9'd77);
    settle();
    @(negedge wclk); rst_n = 1'b0;
    exp_q.delete();
    repeat (2) @(negedge wclk);
    rst_n = 1'b1;
    settle();
    check("R11 empty after second reset", int'(empty), 1);
    check("R11 output register cleared", int'(rd_data), 0);
    @(negedge wclk); load = 1'b1;
    settle();
    rd_ofs("R11 empty offset default", 7);
    rd_ofs("R11 full offset default", 7);
    wr_push(9'd2);
    settle();
    rd_ofs("R11 load sequence restarts at empty offset", 2);
    @(negedge wclk); load = 1'b0;
    settle();

    summary();
    $finish;
  end
endmodule